// File: doc/BRIEF.md
# Power-Domain Duty-Cycle Event Generator

This block paces a processor power domain through alternating active and idle intervals. Software programs two durations in system clock cycles, an active time and an idle time, plus a control word. A down-counter runs out the current interval. When the active interval runs out, the block latches a status flag and, if software has unmasked it, raises an interrupt so that the processor can request sleep. When the idle interval runs out, the block emits a one-cycle wake request and latches a second flag.

How the counter gets its next value depends on a two-bit load-source field. In write-driven mode, software reloads the running interval by rewriting its duration. In event-driven mode, the domain's wake-up and sleep-start indications load the active or idle duration. In free-running mode, the block switches between the two intervals by itself. A flat write port with four addresses is the only software access. Both sticky flags can be seen on an output and are cleared by writing ones.

Top module: `duty_event_gen`

## Requirements
- R1: After reset, irq_o, wake_req_o, phase_o and stat_o are all 0, and the block is disabled.
- R2: While control bit 0 (enable) is 0, the counter is idle and phase_o reads 0. Register writes, wake_in and sleep_in produce no expiry, no status bit and no wake_req_o pulse.
- R3: A control write that sets enable while the block is disabled starts the active interval (phase_o=1) loaded with the active duration. The first active expiry shows on the outputs at the clock edge that comes D cycles after the enabling edge, where D is the effective duration.
- R4: A programmed duration of 0 behaves as a duration of 1.
- R5: With control bits [2:1] = 2 or 3 (free-running), every expiry loads the other interval's duration and flips the phase. Counting k edges after enabling, phase_o = ((k mod (A+B)) < A) and wake_req_o = 1 exactly when k>0 and k mod (A+B) = 0, where A and B are the effective durations.
- R6: With control bits [2:1] = 0 (write-driven), a write to the running interval's duration register (address 0 for active, 1 for idle) reloads the counter with the written value. A write to the other duration register is stored without reloading. wake_in and sleep_in have no effect.
- R7: With control bits [2:1] = 1 (event-driven), sleep_in loads the idle duration and sets the idle phase, and wake_in loads the active duration and sets the active phase. wake_in wins when both are asserted. Duration writes do not reload the counter.
- R8: An active expiry sets status bit 0 (stat_o[0]). irq_o equals stat_o[0] AND control bit 3 (mask enable).
- R9: An idle expiry sets status bit 1 and produces a single-cycle wake_req_o pulse.
- R10: Writing to address 3 clears each status bit whose data bit is 1. An expiry in the same cycle wins over the clear.
- R11: In write-driven and event-driven modes, an expiry leaves the counter idle with the phase unchanged, and no further events follow until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 active duration, 1 idle duration, 2 control, 3 status clear |
| wr_data | input | CNT_W | Write data |
| wake_in | input | 1 | Domain has woken up |
| sleep_in | input | 1 | Domain began its sleep transition |
| irq_o | output | 1 | Masked active-expiry interrupt (level) |
| wake_req_o | output | 1 | One-cycle wake request at idle expiry |
| phase_o | output | 1 | 1 while enabled and in the active interval |
| stat_o | output | 2 | Sticky flags: bit 0 active expiry, bit 1 idle expiry |

## Verification
The hardest state to reach from the ports is a write-driven reload of the idle interval. Write-driven mode never leaves the active phase by itself. The bench therefore enters the idle phase through a sleep_in pulse in event-driven mode and switches to write-driven mode while the block stays enabled, which keeps the counter running. It then rewrites the idle duration and checks that the wake request moves earlier. Free-running timing is swept over a grid of duration pairs, zero included, and each edge's phase and wake output is compared with a modulo formula.

// File: rtl/duty_pkg.sv
package duty_pkg;
  typedef enum logic [1:0] {
    LD_WRITE = 2'd0,
    LD_EVENT = 2'd1,
    LD_AUTO  = 2'd2,
    LD_AUTO2 = 2'd3
  } ld_mode_e;

  typedef enum logic [1:0] {
    RA_ON   = 2'd0,
    RA_OFF  = 2'd1,
    RA_CTRL = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_MODE = 1;
  localparam int CTRL_MASK = 3;
  localparam int NUM_STAT  = 2;
endpackage

// File: rtl/duty_regs.sv
module duty_regs
  import duty_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic                set_on,
  input  logic                set_off,
  output logic [CNT_W-1:0]    on_dur,
  output logic [CNT_W-1:0]    off_dur,
  output logic                en,
  output ld_mode_e            mode,
  output logic                mask,
  output logic [NUM_STAT-1:0] status,
  output logic                on_wr,
  output logic                off_wr,
  output logic                ctrl_wr
);
  logic                stat_wr;
  logic [NUM_STAT-1:0] set_vec;
  logic [NUM_STAT-1:0] status_d;

  always_comb begin
    on_wr   = wr_en && (wr_addr == RA_ON);
    off_wr  = wr_en && (wr_addr == RA_OFF);
    ctrl_wr = wr_en && (wr_addr == RA_CTRL);
    stat_wr = wr_en && (wr_addr == RA_STAT);
    set_vec = {set_off, set_on};
  end

  for (genvar i = 0; i < NUM_STAT; i++) begin : g_stat
    always_comb begin
      status_d[i] = status[i];
      if (stat_wr && wr_data[i]) status_d[i] = 1'b0;
      if (set_vec[i])            status_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_dur  <= '0;
      off_dur <= '0;
    end else begin
      if (on_wr)  on_dur  <= wr_data;
      if (off_wr) off_dur <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= LD_WRITE;
      mask <= 1'b0;
    end else if (ctrl_wr) begin
      en   <= wr_data[CTRL_EN];
      mode <= ld_mode_e'(wr_data[CTRL_MODE +: 2]);
      mask <= wr_data[CTRL_MASK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end
endmodule

// File: rtl/duty_counter.sv
module duty_counter
  import duty_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  ld_mode_e         mode,
  input  logic [CNT_W-1:0] on_dur,
  input  logic [CNT_W-1:0] off_dur,
  input  logic             on_wr,
  input  logic             off_wr,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wake_in,
  input  logic             sleep_in,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_on,
  output logic             on_exp,
  output logic             off_exp,
  output logic             wake_pulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             phase_d;
  logic             expire;
  logic             loaded;
  logic             auto_md;

  function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] d);
    return (d == '0) ? ONE : d;
  endfunction

  always_comb begin
    expire  = en && (cnt == ONE);
    on_exp  = expire && phase_on;
    off_exp = expire && !phase_on;
    auto_md = (mode == LD_AUTO) || (mode == LD_AUTO2);
    cnt_d   = cnt;
    phase_d = phase_on;
    loaded  = 1'b0;
    if (ctrl_wr && !wr_data[CTRL_EN]) begin
      cnt_d   = '0;
      phase_d = 1'b1;
    end else if (ctrl_wr && !en) begin
      cnt_d   = eff(on_dur);
      phase_d = 1'b1;
    end else if (!en) begin
      cnt_d = '0;
    end else begin
      case (mode)
        LD_WRITE: begin
          if (on_wr && phase_on) begin
            cnt_d  = eff(wr_data);
            loaded = 1'b1;
          end else if (off_wr && !phase_on) begin
            cnt_d  = eff(wr_data);
            loaded = 1'b1;
          end
        end
        LD_EVENT: begin
          if (wake_in) begin
            cnt_d   = eff(on_dur);
            phase_d = 1'b1;
            loaded  = 1'b1;
          end else if (sleep_in) begin
            cnt_d   = eff(off_dur);
            phase_d = 1'b0;
            loaded  = 1'b1;
          end
        end
        default: ;
      endcase
      if (!loaded) begin
        if (expire) begin
          if (auto_md) begin
            phase_d = !phase_on;
            cnt_d   = phase_on ? eff(off_dur) : eff(on_dur);
          end else begin
            cnt_d = '0;
          end
        end else if (cnt != '0) begin
          cnt_d = cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      phase_on   <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      cnt        <= cnt_d;
      phase_on   <= phase_d;
      wake_pulse <= off_exp;
    end
  end
endmodule

// File: rtl/duty_event_gen.sv
module duty_event_gen
  import duty_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wake_in,
  input  logic             sleep_in,
  output logic             irq_o,
  output logic             wake_req_o,
  output logic             phase_o,
  output logic [1:0]       stat_o
);
  logic [CNT_W-1:0]    on_dur;
  logic [CNT_W-1:0]    off_dur;
  logic                en_q;
  ld_mode_e            mode_q;
  logic                mask_q;
  logic [NUM_STAT-1:0] status;
  logic                on_wr;
  logic                off_wr;
  logic                ctrl_wr;
  logic [CNT_W-1:0]    cnt_q;
  logic                phase_q;
  logic                on_exp;
  logic                off_exp;
  logic                wake_pulse;

  duty_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .set_on  (on_exp),
    .set_off (off_exp),
    .on_dur  (on_dur),
    .off_dur (off_dur),
    .en      (en_q),
    .mode    (mode_q),
    .mask    (mask_q),
    .status  (status),
    .on_wr   (on_wr),
    .off_wr  (off_wr),
    .ctrl_wr (ctrl_wr)
  );

  duty_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .mode       (mode_q),
    .on_dur     (on_dur),
    .off_dur    (off_dur),
    .on_wr      (on_wr),
    .off_wr     (off_wr),
    .ctrl_wr    (ctrl_wr),
    .wr_data    (wr_data),
    .wake_in    (wake_in),
    .sleep_in   (sleep_in),
    .cnt        (cnt_q),
    .phase_on   (phase_q),
    .on_exp     (on_exp),
    .off_exp    (off_exp),
    .wake_pulse (wake_pulse)
  );

  always_comb begin
    irq_o      = status[0] && mask_q;
    wake_req_o = wake_pulse;
    phase_o    = en_q && phase_q;
    stat_o     = status;
  end
endmodule

// File: rtl/duty_event_gen_chk.sv
module duty_event_gen_chk
  import duty_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             wake_in,
  input logic             sleep_in,
  input logic             en,
  input ld_mode_e         mode,
  input logic             mask,
  input logic [CNT_W-1:0] cnt,
  input logic             phase,
  input logic             irq_o,
  input logic             wake_req_o
);
  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |=> !wake_req_o);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mask);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0));

  // R2
  wake_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> $past(en));

  // R5
  auto_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode[1] && (cnt == CNT_W'(1)) && !(wr_en && wr_addr == RA_CTRL))
    |=> (phase != $past(phase)));

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (cnt > CNT_W'(1)) && !wr_en && !wake_in && !sleep_in)
    |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

bind duty_event_gen duty_event_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wake_in    (wake_in),
  .sleep_in   (sleep_in),
  .en         (en_q),
  .mode       (mode_q),
  .mask       (mask_q),
  .cnt        (cnt_q),
  .phase      (phase_q),
  .irq_o      (irq_o),
  .wake_req_o (wake_req_o)
);

// File: tb/tb_duty_event_gen.sv
module tb_duty_event_gen;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic         wake_in;
  logic         sleep_in;
  logic         irq_o;
  logic         wake_req_o;
  logic         phase_o;
  logic [1:0]   stat_o;

  int vec;
  int miss;
  bit done;

  duty_event_gen #(.CNT_W(W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wake_in    (wake_in),
    .sleep_in   (sleep_in),
    .irq_o      (irq_o),
    .wake_req_o (wake_req_o),
    .phase_o    (phase_o),
    .stat_o     (stat_o)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1ns;
  endtask

  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = 2'(addr);
    wr_data = W'(data);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit wk, input bit sl);
    wake_in  = wk;
    sleep_in = sl;
    tick();
    wake_in  = 1'b0;
    sleep_in = 1'b0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  endtask

  initial begin
    #(4ns * 200000);
    vec++;
    miss++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int offs[3];
    int ons[5];
    ons  = '{0, 1, 2, 3, 5};
    offs = '{0, 1, 4};
    vec = 0; miss = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    wake_in = 1'b0; sleep_in = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_req_o, 0);
    chk("R1 phase", phase_o, 0);
    chk("R1 stat", stat_o, 0);

    // R2 disabled: writes and domain events do nothing
    wr(0, 1); wr(1, 1);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      tick();
      chk("R2 wake", wake_req_o, 0);
      chk("R2 stat", stat_o, 0);
      chk("R2 phase", phase_o, 0);
    end

    // R3 R4 R5 R8 R9 free-running sweep
    foreach (ons[i]) begin
      foreach (offs[j]) begin
        int a, b, p;
        a = eff(ons[i]); b = eff(offs[j]); p = a + b;
        wr(0, ons[i]); wr(1, offs[j]);
        wr(2, 1 | (2 << 1) | (1 << 3));
        chk("R3 start phase", phase_o, 1);
        for (int k = 1; k <= 2 * p + 1; k++) begin
          tick();
          chk("R5 phase", phase_o, ((k % p) < a) ? 1 : 0);
          chk("R9 wake", wake_req_o, ((k % p) == 0) ? 1 : 0);
          chk("R4 R8 irq", irq_o, (k >= a) ? 1 : 0);
        end
        wr(2, 0);
        wr(3, 3);
        chk("R10 stat cleared", stat_o, 0);
        chk("R2 phase off", phase_o, 0);
        chk("R2 no wake", wake_req_o, 0);
      end
    end

    // R8 mask off: status set, irq held low
    wr(0, 2); wr(1, 2);
    wr(2, 1 | (3 << 1));
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R8 masked irq", irq_o, 0);
      chk("R8 stat0", int'(stat_o[0]), (k >= 2) ? 1 : 0);
    end
    wr(2, 0); wr(3, 3);

    // R6 R11 write-driven mode
    wr(0, 6); wr(1, 9);
    wr(2, 1 | (0 << 1) | (1 << 3));
    tick(); tick();
    wr(1, 1);
    for (int k = 4; k <= 10; k++) begin
      tick();
      chk("R6 R11 stat0", int'(stat_o[0]), (k >= 6) ? 1 : 0);
      chk("R11 phase held", phase_o, 1);
      chk("R11 no wake", wake_req_o, 0);
    end
    wr(3, 1);
    chk("R10 partial clear", stat_o, 0);
    wr(0, 3);
    tick(); chk("R6 reload early", int'(stat_o[0]), 0);
    tick(); chk("R6 reload early", int'(stat_o[0]), 0);
    tick(); chk("R6 reload expiry", int'(stat_o[0]), 1);
    wr(3, 3);
    pulse(1'b0, 1'b1);
    chk("R6 sleep ignored", phase_o, 1);

    // R7 event-driven mode
    wr(1, 4);
    wr(2, 1 | (1 << 1) | (1 << 3));
    pulse(1'b0, 1'b1);
    chk("R7 sleep phase", phase_o, 0);
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk("R7 R9 wake", wake_req_o, (k == 4) ? 1 : 0);
      chk("R7 phase", phase_o, 0);
    end
    wr(1, 2);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R7 write no reload", wake_req_o, 0);
    end
    wr(3, 3);
    pulse(1'b1, 1'b0);
    chk("R7 wake phase", phase_o, 1);
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R7 on expiry", int'(stat_o[0]), (k >= 3) ? 1 : 0);
    end
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    chk("R7 wake wins", phase_o, 1);

    // R6 idle-phase reload reached through event mode then write mode
    wr(3, 3);
    wr(1, 6);
    pulse(1'b0, 1'b1);
    wr(2, 1 | (0 << 1) | (1 << 3));
    wr(1, 2);
    tick(); chk("R6 off reload early", wake_req_o, 0);
    tick(); chk("R6 off reload wake", wake_req_o, 1);
    tick(); chk("R6 off reload single", wake_req_o, 0);
    tick(); chk("R6 no late wake", wake_req_o, 0);
    pulse(1'b1, 1'b0);
    chk("R6 wake ignored", phase_o, 0);

    wr(2, 0);
    finish_run();
  end
endmodule